// File: doc/BRIEF.md
# Debug Module Select Decoder

This block sits between a JTAG TAP controller and the set of debug sub-modules behind a single debug data register. It watches the serial bit stream of each data-register scan and, at Update-DR, decides what the scan was. The last bit shifted in, which is the most significant bit of the scan, is a flag. If the flag is 1, the scan is a select command, and the two bits shifted just before it name the sub-module to make active. If the flag is 0, the scan was a command for the sub-module already selected.

The active sub-module receives gated copies of the capture, shift and update strobes, and its serial output is routed back to `tdo`. The identifier values are 0 for the system-bus access module, 1 for the first CPU, 2 for the second CPU and 3 for the serial console. After TAP reset no module is active, and the selection holds until the next select command. An identifier at or above `NUM_MODULES` is rejected: it leaves no module active and raises an error flag.

Top module: `dbg_chain_selector`

## Requirements
- R1: While reset is held and after it is released, `mod_en`, `mod_shift`, `mod_capture` and `mod_update` are all zero, `tdo` is 0 and `sel_err` is 0.
- R2: A scan whose last shifted bit is 1 selects the module whose identifier is the two bits shifted just before the flag, with the earlier of the two as bit 0. From the clock after Update-DR, `mod_en` is one-hot at that identifier: 0 is the bus module, 1 is CPU0, 2 is CPU1, 3 is the serial port.
- R3: A scan whose last shifted bit is 0 leaves the selection unchanged. During its Update-DR cycle it drives `mod_update` high for the selected module only.
- R4: During the Update-DR cycle of a select scan, `mod_update` is zero for every module.
- R5: `mod_shift` and `mod_capture` copy `shift_dr` and `capture_dr` to the selected module only, and they are all zero while no module is selected.
- R6: `tdo` equals the `mod_tdo` bit of the selected module, and it is 0 while no module is selected.
- R7: A selection persists across any number of command scans of any length until the next select scan.
- R8: A select scan with an identifier of `NUM_MODULES` or more leaves no module selected and sets `sel_err`. The next legal select clears `sel_err`.
- R9: Only the last three shifted bits decide a select. A longer scan that ends with flag 1 selects by its two preceding bits.
- R10: Before any select after reset, a command scan produces no `mod_update`, `mod_shift` or `mod_capture` activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low TAP reset |
| capture_dr | input | 1 | Capture-DR strobe for the debug register |
| shift_dr | input | 1 | Shift-DR strobe for the debug register |
| update_dr | input | 1 | Update-DR strobe for the debug register |
| tdi | input | 1 | Serial data in |
| mod_tdo | input | NUM_MODULES | Serial outputs of the sub-modules |
| tdo | output | 1 | Serial data out |
| mod_en | output | NUM_MODULES | One-hot active-module enable |
| mod_capture | output | NUM_MODULES | Capture strobe per module |
| mod_shift | output | NUM_MODULES | Shift strobe per module |
| mod_update | output | NUM_MODULES | Update strobe per module, suppressed for select scans |
| sel_err | output | 1 | Last select named an absent module |

## Verification
The bench builds two instances from the same stimulus. The first uses the default four modules and `ID_W` of 2, so every identifier is legal and all four enables are reachable. The second uses three modules, which makes identifier 3 illegal and brings the error path of R8 within reach. The vector table also holds scans longer than three bits, ending in either flag value, so that R9 and R7 are exercised on the same flow.

// File: rtl/dbg_chain_selector.sv
module dbg_chain_selector #(
  parameter int NUM_MODULES = 4,
  parameter int ID_W        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture_dr,
  input  logic                   shift_dr,
  input  logic                   update_dr,
  input  logic                   tdi,
  input  logic [NUM_MODULES-1:0] mod_tdo,
  output logic                   tdo,
  output logic [NUM_MODULES-1:0] mod_en,
  output logic [NUM_MODULES-1:0] mod_capture,
  output logic [NUM_MODULES-1:0] mod_shift,
  output logic [NUM_MODULES-1:0] mod_update,
  output logic                   sel_err
);
  localparam int CMD_W = ID_W + 1;

  logic [CMD_W-1:0] cmd_q;
  logic [ID_W-1:0]  id_q;
  logic             active_q;
  logic             err_q;

  wire             sel_flag = cmd_q[CMD_W-1];
  wire [ID_W-1:0]  req_id   = cmd_q[ID_W-1:0];
  wire             id_legal = (32'(req_id) < 32'(NUM_MODULES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      id_q     <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (shift_dr)
        cmd_q <= {tdi, cmd_q[CMD_W-1:1]};
      if (update_dr && sel_flag) begin
        if (id_legal) begin
          id_q     <= req_id;
          active_q <= 1'b1;
          err_q    <= 1'b0;
        end else begin
          active_q <= 1'b0;
          err_q    <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_MODULES; i++) begin : g_route
    assign mod_en[i]      = active_q && (id_q == ID_W'(i));
    assign mod_capture[i] = capture_dr && mod_en[i];
    assign mod_shift[i]   = shift_dr && mod_en[i];
    assign mod_update[i]  = update_dr && !sel_flag && mod_en[i];
  end

  assign tdo     = |(mod_tdo & mod_en);
  assign sel_err = err_q;
endmodule

module dbg_chain_selector_chk #(
  parameter int NUM_MODULES = 4,
  parameter int ID_W        = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   update_dr,
  input logic                   tdo,
  input logic [NUM_MODULES-1:0] mod_en,
  input logic [NUM_MODULES-1:0] mod_capture,
  input logic [NUM_MODULES-1:0] mod_shift,
  input logic [NUM_MODULES-1:0] mod_update,
  input logic                   sel_err
);
  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mod_en)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en == '0) |-> (tdo == 1'b0 && mod_shift == '0 && mod_capture == '0)); // R5
  AST_UPD_TO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((mod_update & ~mod_en) == '0)); // R3
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_dr |=> $stable(mod_en)); // R7
  AST_ERR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> (mod_en == '0)); // R8
endmodule

bind dbg_chain_selector dbg_chain_selector_chk #(.NUM_MODULES(NUM_MODULES), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .update_dr(update_dr), .tdo(tdo), .mod_en(mod_en),
  .mod_capture(mod_capture), .mod_shift(mod_shift), .mod_update(mod_update), .sel_err(sel_err));

// File: tb/dbg_chain_selector_tb.sv
`timescale 1ns/1ps
module dbg_chain_selector_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic [3:0] mod_tdo = 4'b0000;
  logic tdo;
  logic [3:0] mod_en, mod_capture, mod_shift, mod_update;
  logic sel_err;
  logic [2:0] mod_tdo3 = 3'b000;
  logic tdo3;
  logic [2:0] en3, cap3, sh3, upd3;
  logic err3;
  int checks = 0, errors = 0;
  logic [3:0] upd_snap, sh_snap;

  always #2.5 clk = ~clk;

  dbg_chain_selector u_dut (.clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .mod_tdo(mod_tdo), .tdo(tdo), .mod_en(mod_en),
    .mod_capture(mod_capture), .mod_shift(mod_shift), .mod_update(mod_update), .sel_err(sel_err));

  dbg_chain_selector #(.NUM_MODULES(3)) u_dut_m3 (.clk(clk), .rst_n(rst_n), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .mod_tdo(mod_tdo3), .tdo(tdo3),
    .mod_en(en3), .mod_capture(cap3), .mod_shift(sh3), .mod_update(upd3), .sel_err(err3));

  typedef struct packed {
    logic [3:0]  len;
    logic [11:0] data;
    logic [3:0]  en;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{4'd3,  12'b110,          4'b0100},
    '{4'd5,  12'b00101,        4'b0100},
    '{4'd3,  12'b100,          4'b0001},
    '{4'd3,  12'b111,          4'b1000},
    '{4'd10, 12'b1010101010,   4'b0010},
    '{4'd12, 12'h7FF,          4'b0010},
    '{4'd3,  12'b101,          4'b0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [11:0] data, input int len);
    sh_snap = 4'b0000;
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      shift_dr = 1; tdi = data[b];
      #1 sh_snap = sh_snap | mod_shift;
    end
    @(negedge clk);
    shift_dr = 0; tdi = 0; update_dr = 1;
    #1 upd_snap = mod_update;
    @(negedge clk);
    update_dr = 0;
    #1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    repeat (3) @(negedge clk);
    #1 chk("R1 en in reset", {mod_en, mod_shift, mod_update, tdo, sel_err}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 after reset", {mod_en, mod_capture, tdo, sel_err}, 0);
    mod_tdo = 4'b1111;
    #1 chk("R6 tdo none", tdo, 0);

    scan(12'b00011, 5);
    chk("R10 no update", upd_snap, 0);
    chk("R10 no shift", sh_snap, 0);
    chk("R10 still none", mod_en, 0);
    @(negedge clk); capture_dr = 1; #1 chk("R5 no capture", mod_capture, 0);
    @(negedge clk); capture_dr = 0;

    for (int v = 0; v < 7; v++) begin
      prev = mod_en;
      scan(VEC[v].data, int'(VEC[v].len));
      chk($sformatf("R2 R7 R9 sel v%0d", v), mod_en, VEC[v].en);
      if (VEC[v].data[VEC[v].len - 1])
        chk($sformatf("R4 no upd v%0d", v), upd_snap, 0);
      else
        chk($sformatf("R3 upd v%0d", v), upd_snap, prev);
      chk($sformatf("R5 shift v%0d", v), sh_snap, prev);
      mod_tdo = VEC[v].en;
      #1 chk($sformatf("R6 tdo hi v%0d", v), tdo, 1);
      mod_tdo = ~VEC[v].en;
      #1 chk($sformatf("R6 tdo lo v%0d", v), tdo, 0);
      @(negedge clk); capture_dr = 1;
      #1 chk($sformatf("R5 capture v%0d", v), mod_capture, VEC[v].en);
      @(negedge clk); capture_dr = 0;
    end

    scan(12'b111, 3);
    chk("R8 illegal none", en3, 0);
    chk("R8 err set", err3, 1);
    chk("R8 wide legal", mod_en, 4'b1000);
    chk("R8 wide no err", sel_err, 0);
    mod_tdo3 = 3'b111;
    #1 chk("R6 tdo after illegal", tdo3, 0);
    scan(12'b00001, 5);
    chk("R8 err held", err3, 1);
    chk("R10 no upd after illegal", {1'b0, upd3}, 0);
    scan(12'b100, 3);
    chk("R8 err cleared", err3, 0);
    chk("R8 reselect", en3, 3'b001);

    rst_n = 0;
    #1 chk("R1 reset clears", {mod_en, en3, sel_err, err3, tdo}, 0);
    @(negedge clk); rst_n = 1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule